// File: doc/BRIEF.md
# Interrupt and trap controller

This block decides which pending interrupt or trap a small processor core services next. It runs a fixed-priority order. Ordinary interrupt lines latch into pending bits. The highest-numbered pending line wins at an instruction boundary, unless a service routine is already running. The two trap sources are never masked and always outrank ordinary interrupts:

- a debug trap, raised by a local breakpoint or by a shared trap pin;
- a user trap.

A trap is held back for a fixed number of cycles before it may be taken. The instruction in flight always completes first, however long its wait states last.

When a source is taken, the block does the following:

- It emits a one-cycle taken pulse together with the service address.
- It drives a 4-bit status code naming the serviced source.
- It freezes a return-address register, which otherwise follows the core's program counter.

A debug trap does not change the status code. Instead, it forces the program-memory-map select to the on-chip ROM map until the routine returns.

The trap pin is bidirectional. In output mode, a device drives the pin high while its own breakpoint is pending, so that other devices on the same net follow it into debug code. In input mode, the pin is a debug-trap source.

Top module: `irq_trap_ctrl`

## Requirements
- R1: After reset the following hold: `vec_taken` is 0, `vec_code` is 0, `map_sel` equals `map_cfg`, and `trap_pin_oe` and `trap_pin_o` are 0.
- R2: A pulse on `irq_req[i]` is latched as pending. At the next cycle with `insn_done` high, the source is taken. `vec_taken` then goes high for one cycle, on the clock edge that ends that boundary cycle. On the same edge `vec_addr` becomes 0x10 + 4*i and `vec_code` becomes i+1.
- R3: Among pending ordinary interrupts, the highest index wins. Taking a source clears only that source's pending bit, so a losing source is taken at a later boundary.
- R4: Ordinary interrupts are not taken while a service routine is active. An `ireturn` pulse unmasks them in its own cycle, so a pending interrupt can be taken at the same boundary as the `ireturn`.
- R5: Traps are never masked. A ready debug trap beats a ready user trap, and any ready trap beats an ordinary interrupt.
- R6: A trap request sampled on clock edge k raises `vec_taken` after edge k+4, provided `insn_done` is high in the cycle before that edge. If `insn_done` is low, the take waits for the next cycle in which `insn_done` is high.
- R7: A user trap is taken with `vec_addr` 0x46 and `vec_code` 0xF.
- R8: `ret_addr` has three behaviours:
  - Outside a service routine, it follows `pc_in` one cycle late.
  - On every take it captures `pc_in`, and it then holds while the routine runs.
  - A trap taken inside a routine overwrites it with the current `pc_in`.
- R9: A debug trap is taken with `vec_addr` 0x3 and leaves `vec_code` unchanged. It can be raised by `bkpt_req`, or by `trap_pin_i` when in input mode.
- R10: While a debug trap is being serviced, `map_sel` equals `ROM_MAP` (default 1). After `ireturn`, `map_sel` follows `map_cfg` again.
- R11: `vec_code` is 0 whenever no source is in service. `ireturn` clears it.
- R12: With `trap_pin_is_out` high, the pin behaves as an output:
  - `trap_pin_oe` is 1.
  - `trap_pin_o` is 1 from the edge that samples `bkpt_req` until the edge that takes that debug trap.
  - `trap_pin_i` is ignored.

  With `trap_pin_is_out` low, both pin outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_req | input | NIRQ | Ordinary interrupt requests; a higher index has higher priority |
| usr_trap_req | input | 1 | User trap request |
| bkpt_req | input | 1 | Local breakpoint (debug trap) request |
| trap_pin_i | input | 1 | Trap pin input value |
| trap_pin_is_out | input | 1 | Trap pin direction: 1 = output |
| insn_done | input | 1 | Instruction-boundary strobe |
| ireturn | input | 1 | Return-from-service strobe |
| pc_in | input | 16 | Current next-instruction address from the core |
| map_cfg | input | MAP_W | Program map selected by software |
| vec_taken | output | 1 | One-cycle pulse when a source is taken |
| vec_addr | output | 16 | Service vector address |
| vec_code | output | 4 | Status code of the source in service |
| ret_addr | output | 16 | Saved return address |
| map_sel | output | MAP_W | Effective program map select |
| trap_pin_oe | output | 1 | Trap pin output enable |
| trap_pin_o | output | 1 | Trap pin output value |

## Verification
The interesting collision is an `ireturn` that lands on the same boundary as an ordinary interrupt that went pending while it was masked. The bench provokes this by raising a second interrupt inside a routine and then pulsing `ireturn`. It expects the new source to be taken on that edge, with its own vector, code and a freshly captured return address. A second collision pits a matured user trap against an interrupt that became pending in the same cycle. The bench expects the trap vector there, and then expects the interrupt to be taken at the `ireturn` that closes the trap routine.

// File: rtl/irq_trap_pkg.sv
package irq_trap_pkg;

    localparam int PC_W     = 16;
    localparam int VEC_W    = 4;
    localparam int IRQ_STEP = 4;

    localparam logic [PC_W-1:0]  DBG_VEC  = 16'h0003;
    localparam logic [PC_W-1:0]  USR_VEC  = 16'h0046;
    localparam logic [PC_W-1:0]  IRQ_BASE = 16'h0010;
    localparam logic [VEC_W-1:0] USR_CODE = 4'hF;

    typedef enum logic [1:0] {
        SRC_NONE,
        SRC_IRQ,
        SRC_USR,
        SRC_DBG
    } src_e;

    typedef struct packed {
        logic             fire;
        src_e             src;
        logic [PC_W-1:0]  addr;
        logic [VEC_W-1:0] code;
    } take_t;

    function automatic logic [PC_W-1:0] irq_vector(input int idx);
        return IRQ_BASE + PC_W'(idx * IRQ_STEP);
    endfunction

    function automatic logic [VEC_W-1:0] irq_code(input int idx);
        return VEC_W'(idx + 1);
    endfunction

endpackage

// File: rtl/irq_pend_arb.sv
module irq_pend_arb #(
    parameter int N = 8
) (
    input  logic                              clk,
    input  logic                              rst,
    input  logic [N-1:0]                      req,
    input  logic                              ack,
    output logic                              any,
    output logic [((N > 1) ? $clog2(N) : 1)-1:0] idx,
    output logic [N-1:0]                      grant
);
    localparam int IDX_W = (N > 1) ? $clog2(N) : 1;

    logic [N-1:0] pend;

    always_ff @(posedge clk) begin
        if (rst) pend <= '0;
        else     pend <= (pend & ~(grant & {N{ack}})) | req;
    end

    // highest index wins
    always_comb begin
        grant = '0;
        idx   = '0;
        any   = |pend;
        for (int i = 0; i < N; i++) begin
            if (pend[i]) begin
                grant    = '0;
                grant[i] = 1'b1;
                idx      = IDX_W'(i);
            end
        end
    end

    // R3
    grant_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(grant));

    // R3
    ack_clears_winner_chk: assert property (@(posedge clk) disable iff (rst)
        ack |=> ((pend & $past(grant) & ~$past(req)) == '0));

endmodule

// File: rtl/trap_delay.sv
module trap_delay #(
    parameter int LAT = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic req,
    input  logic ack,
    output logic pend,
    output logic ready
);
    localparam int CW = $clog2(LAT + 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || ack) begin
            pend <= 1'b0;
            cnt  <= '0;
        end else if (!pend) begin
            if (req) begin
                pend <= 1'b1;
                cnt  <= CW'(1);
            end
        end else if (cnt != CW'(LAT)) begin
            cnt <= cnt + CW'(1);
        end
    end

    assign ready = pend && (cnt == CW'(LAT));

    // R6
    ready_after_pend_chk: assert property (@(posedge clk) disable iff (rst)
        ready |-> $past(pend));

endmodule

// File: rtl/irq_trap_ctrl.sv
module irq_trap_ctrl
    import irq_trap_pkg::*;
#(
    parameter int NIRQ     = 8,
    parameter int TRAP_LAT = 4,
    parameter int MAP_W    = 2,
    parameter int ROM_MAP  = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NIRQ-1:0]   irq_req,
    input  logic              usr_trap_req,
    input  logic              bkpt_req,
    input  logic              trap_pin_i,
    input  logic              trap_pin_is_out,
    input  logic              insn_done,
    input  logic              ireturn,
    input  logic [PC_W-1:0]   pc_in,
    input  logic [MAP_W-1:0]  map_cfg,
    output logic              vec_taken,
    output logic [PC_W-1:0]   vec_addr,
    output logic [VEC_W-1:0]  vec_code,
    output logic [PC_W-1:0]   ret_addr,
    output logic [MAP_W-1:0]  map_sel,
    output logic              trap_pin_oe,
    output logic              trap_pin_o
);
    localparam int IDX_W  = (NIRQ > 1) ? $clog2(NIRQ) : 1;
    localparam int NTRAP  = 2;
    localparam int T_DBG  = 0;
    localparam int T_USR  = 1;

    logic [NTRAP-1:0] trap_req, trap_ack, trap_pend, trap_ready;
    logic             irq_any, irq_ack;
    logic [IDX_W-1:0] irq_idx;
    logic [NIRQ-1:0]  irq_grant;
    logic             in_isr, dbg_active;
    take_t            take;

    assign trap_req[T_DBG] = bkpt_req | (trap_pin_i & ~trap_pin_is_out);
    assign trap_req[T_USR] = usr_trap_req;

    for (genvar t = 0; t < NTRAP; t++) begin : g_trap
        trap_delay #(.LAT(TRAP_LAT)) u_dly (
            .clk   (clk),
            .rst   (rst),
            .req   (trap_req[t]),
            .ack   (trap_ack[t]),
            .pend  (trap_pend[t]),
            .ready (trap_ready[t])
        );
    end

    irq_pend_arb #(.N(NIRQ)) u_arb (
        .clk   (clk),
        .rst   (rst),
        .req   (irq_req),
        .ack   (irq_ack),
        .any   (irq_any),
        .idx   (irq_idx),
        .grant (irq_grant)
    );

    always_comb begin
        take = '{fire: 1'b0, src: SRC_NONE, addr: '0, code: '0};
        if (insn_done) begin
            if (trap_ready[T_DBG]) begin
                take = '{fire: 1'b1, src: SRC_DBG, addr: DBG_VEC, code: '0};
            end else if (trap_ready[T_USR]) begin
                take = '{fire: 1'b1, src: SRC_USR, addr: USR_VEC, code: USR_CODE};
            end else if (irq_any && (!in_isr || ireturn)) begin
                take = '{fire: 1'b1, src: SRC_IRQ,
                         addr: irq_vector(int'(irq_idx)),
                         code: irq_code(int'(irq_idx))};
            end
        end
    end

    assign trap_ack[T_DBG] = take.fire && (take.src == SRC_DBG);
    assign trap_ack[T_USR] = take.fire && (take.src == SRC_USR);
    assign irq_ack         = take.fire && (take.src == SRC_IRQ);

    always_ff @(posedge clk) begin
        if (rst) begin
            vec_taken  <= 1'b0;
            vec_addr   <= '0;
            vec_code   <= '0;
            ret_addr   <= '0;
            in_isr     <= 1'b0;
            dbg_active <= 1'b0;
        end else begin
            vec_taken <= take.fire;
            if (take.fire) vec_addr <= take.addr;
            if (take.fire && take.src != SRC_DBG) vec_code <= take.code;
            else if (ireturn)                     vec_code <= '0;
            in_isr     <= take.fire | (in_isr & ~ireturn);
            dbg_active <= (take.fire && take.src == SRC_DBG) | (dbg_active & ~ireturn);
            if (take.fire || !in_isr || ireturn) ret_addr <= pc_in;
        end
    end

    assign map_sel     = dbg_active ? MAP_W'(ROM_MAP) : map_cfg;
    assign trap_pin_oe = trap_pin_is_out;
    assign trap_pin_o  = trap_pin_is_out & trap_pend[T_DBG];

    // R2
    take_at_boundary_chk: assert property (@(posedge clk) disable iff (rst)
        vec_taken |-> $past(insn_done));

    // R4
    isr_masks_irq_chk: assert property (@(posedge clk) disable iff (rst)
        (vec_taken && $past(in_isr) && !$past(ireturn))
            |-> (vec_addr == DBG_VEC || vec_addr == USR_VEC));

    // R9
    dbg_keeps_code_chk: assert property (@(posedge clk) disable iff (rst)
        (vec_taken && vec_addr == DBG_VEC && !$past(ireturn))
            |-> (vec_code == $past(vec_code)));

    // R11
    idle_code_zero_chk: assert property (@(posedge clk) disable iff (rst)
        !in_isr |-> (vec_code == '0));

endmodule

// File: tb/irq_trap_ctrl_tb.sv
module irq_trap_ctrl_tb;
    import irq_trap_pkg::*;

    localparam int NIRQ  = 8;
    localparam int MAP_W = 2;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [NIRQ-1:0]   irq_req = '0;
    logic              usr_trap_req = 1'b0;
    logic              bkpt_req = 1'b0;
    logic              trap_pin_i = 1'b0;
    logic              trap_pin_is_out = 1'b0;
    logic              insn_done = 1'b1;
    logic              ireturn = 1'b0;
    logic [PC_W-1:0]   pc_in = 16'h0100;
    logic [MAP_W-1:0]  map_cfg = 2'd2;
    logic              vec_taken;
    logic [PC_W-1:0]   vec_addr;
    logic [VEC_W-1:0]  vec_code;
    logic [PC_W-1:0]   ret_addr;
    logic [MAP_W-1:0]  map_sel;
    logic              trap_pin_oe;
    logic              trap_pin_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    irq_trap_ctrl #(.NIRQ(NIRQ)) u_dut (
        .clk(clk), .rst(rst), .irq_req(irq_req), .usr_trap_req(usr_trap_req),
        .bkpt_req(bkpt_req), .trap_pin_i(trap_pin_i), .trap_pin_is_out(trap_pin_is_out),
        .insn_done(insn_done), .ireturn(ireturn), .pc_in(pc_in), .map_cfg(map_cfg),
        .vec_taken(vec_taken), .vec_addr(vec_addr), .vec_code(vec_code),
        .ret_addr(ret_addr), .map_sel(map_sel), .trap_pin_oe(trap_pin_oe),
        .trap_pin_o(trap_pin_o)
    );

    task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s act=%h exp=%h at %0t", r, act, exp, $time);
        end
    endtask

    task automatic pulse_irq(input logic [NIRQ-1:0] m);
        irq_req = m;
        @(negedge clk);
        irq_req = '0;
    endtask

    task automatic do_iret();
        ireturn = 1'b1;
        @(negedge clk);
        ireturn = 1'b0;
    endtask

    // called one negedge after the request edge; checks the four-cycle window
    task automatic wait_trap(input string r);
        chk(r, 32'(vec_taken), 32'd0);
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            chk(r, 32'(vec_taken), 32'd0);
        end
        @(negedge clk);
        chk(r, 32'(vec_taken), 32'd1);
    endtask

    task automatic t_reset();
        chk("R1 taken", 32'(vec_taken), 32'd0);
        chk("R1 code", 32'(vec_code), 32'd0);
        chk("R1 map", 32'(map_sel), 32'd2);
        chk("R1 oe", 32'(trap_pin_oe), 32'd0);
        chk("R1 pin", 32'(trap_pin_o), 32'd0);
        pc_in = 16'h0110;
        @(negedge clk);
        chk("R8 tracks pc", 32'(ret_addr), 32'h0110);
    endtask

    task automatic t_irq_mask();
        pc_in = 16'h0120;
        pulse_irq(8'b0000_0100);
        @(negedge clk);
        chk("R2 taken", 32'(vec_taken), 32'd1);
        chk("R2 addr", 32'(vec_addr), 32'h0018);
        chk("R2 code", 32'(vec_code), 32'd3);
        chk("R8 capture", 32'(ret_addr), 32'h0120);
        @(negedge clk);
        chk("R2 one pulse", 32'(vec_taken), 32'd0);
        pc_in = 16'h0300;
        pulse_irq(8'b0010_0000);
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            chk("R4 masked", 32'(vec_taken), 32'd0);
            chk("R8 held", 32'(ret_addr), 32'h0120);
        end
        do_iret();
        chk("R4 iret take", 32'(vec_taken), 32'd1);
        chk("R4 addr", 32'(vec_addr), 32'h0024);
        chk("R4 code", 32'(vec_code), 32'd6);
        chk("R8 recapture", 32'(ret_addr), 32'h0300);
        do_iret();
        chk("R11 cleared", 32'(vec_code), 32'd0);
        chk("R11 no take", 32'(vec_taken), 32'd0);
    endtask

    task automatic t_priority();
        pulse_irq(8'b0100_0010);
        @(negedge clk);
        chk("R3 winner", 32'(vec_code), 32'd7);
        chk("R3 addr", 32'(vec_addr), 32'h0028);
        do_iret();
        chk("R3 loser taken", 32'(vec_taken), 32'd1);
        chk("R3 loser code", 32'(vec_code), 32'd2);
        do_iret();
        chk("R3 none left", 32'(vec_taken), 32'd0);
        chk("R11 zero", 32'(vec_code), 32'd0);
    endtask

    task automatic t_usr_latency();
        pc_in = 16'h0400;
        usr_trap_req = 1'b1;
        @(negedge clk);
        usr_trap_req = 1'b0;
        wait_trap("R6 latency");
        chk("R7 addr", 32'(vec_addr), 32'h0046);
        chk("R7 code", 32'(vec_code), 32'hF);
        chk("R8 trap ret", 32'(ret_addr), 32'h0400);
        do_iret();
    endtask

    task automatic t_boundary_wait();
        insn_done = 1'b0;
        usr_trap_req = 1'b1;
        @(negedge clk);
        usr_trap_req = 1'b0;
        for (int k = 0; k < 7; k++) begin
            @(negedge clk);
            chk("R6 waits boundary", 32'(vec_taken), 32'd0);
        end
        insn_done = 1'b1;
        @(negedge clk);
        chk("R6 taken at boundary", 32'(vec_taken), 32'd1);
        chk("R6 addr", 32'(vec_addr), 32'h0046);
        do_iret();
    endtask

    task automatic t_trap_in_isr();
        pc_in = 16'h0500;
        pulse_irq(8'b0000_0001);
        @(negedge clk);
        chk("R2 irq0 code", 32'(vec_code), 32'd1);
        pc_in = 16'h0520;
        usr_trap_req = 1'b1;
        @(negedge clk);
        usr_trap_req = 1'b0;
        wait_trap("R5 trap in isr");
        chk("R8 overwrite", 32'(ret_addr), 32'h0520);
        chk("R7 code in isr", 32'(vec_code), 32'hF);
        do_iret();
    endtask

    task automatic t_dbg_map();
        pc_in = 16'h0600;
        pulse_irq(8'b0000_1000);
        @(negedge clk);
        chk("R2 irq3 code", 32'(vec_code), 32'd4);
        bkpt_req = 1'b1;
        @(negedge clk);
        bkpt_req = 1'b0;
        chk("R12 input mode pin", 32'(trap_pin_o), 32'd0);
        wait_trap("R9 dbg latency");
        chk("R9 addr", 32'(vec_addr), 32'h0003);
        chk("R9 code kept", 32'(vec_code), 32'd4);
        chk("R10 rom map", 32'(map_sel), 32'd1);
        do_iret();
        chk("R10 restored", 32'(map_sel), 32'd2);
        chk("R11 zero after", 32'(vec_code), 32'd0);
    endtask

    task automatic t_pin_out();
        trap_pin_is_out = 1'b1;
        trap_pin_i = 1'b1;
        @(negedge clk);
        chk("R12 oe", 32'(trap_pin_oe), 32'd1);
        for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            chk("R12 input ignored", 32'(vec_taken), 32'd0);
        end
        trap_pin_i = 1'b0;
        bkpt_req = 1'b1;
        @(negedge clk);
        bkpt_req = 1'b0;
        chk("R12 pin driven", 32'(trap_pin_o), 32'd1);
        wait_trap("R12 local trap");
        chk("R12 pin released", 32'(trap_pin_o), 32'd0);
        chk("R9 addr", 32'(vec_addr), 32'h0003);
        do_iret();
        trap_pin_is_out = 1'b0;
        @(negedge clk);
        chk("R12 oe off", 32'(trap_pin_oe), 32'd0);
    endtask

    task automatic t_pin_in();
        trap_pin_i = 1'b1;
        @(negedge clk);
        trap_pin_i = 1'b0;
        wait_trap("R9 pin trap");
        chk("R9 pin addr", 32'(vec_addr), 32'h0003);
        chk("R9 idle code", 32'(vec_code), 32'd0);
        chk("R10 pin map", 32'(map_sel), 32'd1);
        do_iret();
    endtask

    task automatic t_trap_beats_irq();
        usr_trap_req = 1'b1;
        @(negedge clk);
        usr_trap_req = 1'b0;
        @(negedge clk);
        @(negedge clk);
        irq_req = 8'b1000_0000;
        @(negedge clk);
        irq_req = '0;
        @(negedge clk);
        chk("R5 trap first", 32'(vec_addr), 32'h0046);
        chk("R5 taken", 32'(vec_taken), 32'd1);
        do_iret();
        chk("R5 irq after", 32'(vec_code), 32'd8);
        chk("R5 irq addr", 32'(vec_addr), 32'h002C);
        do_iret();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_irq_mask();
        t_priority();
        t_usr_latency();
        t_boundary_wait();
        t_trap_in_isr();
        t_dbg_map();
        t_pin_out();
        t_pin_in();
        t_trap_beats_irq();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog act=hung exp=finished");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

endmodule